// File: doc/BRIEF.md
# Two-Level Serial Interrupt Router

This block gathers every interrupt-worthy event of a buffered serial port and steers each one onto one of two interrupt lines. The events are completion and suspension pulses from the transfer groups, five error pulses from the serial engine, and receive overruns. The block detects overruns by watching the write port of the receive buffer RAM. It tracks an empty bit and an overrun bit for every receive slot. A write into a slot that has not been read since its last fill marks that slot overrun and raises a shared overrun flag.

Each event source has its own enable bit and its own line-select bit, held in a small register file. Events latch into a flag register that software clears by writing ones. Each line has a vector that names the most important pending event mapped to it. Transfer-group events come before errors, and the lowest-numbered group comes first. All errors on one line share a single vector code, so software finds the failing slot by scanning the per-slot flags. A separate output reports an uncorrectable RAM error, but only when multi-buffer mode and RAM parity checking are both switched on.

Top module: `sirq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge, both lines are low and every flag is 0. Both vectors read 0, the enable and select registers are 0, every slot reads empty, and no slot reads overrun.
- R2: A RAM write into a slot whose empty bit is 0 sets that slot's overrun bit and global flag bit 5 at the same edge. A write into an empty slot clears its empty bit without raising an overrun.
- R3: A slot read sets that slot's empty bit and clears its overrun bit. A read and a write to the same slot in the same cycle leave the slot non-empty with no overrun and raise no global overrun flag.
- R4: The flag register latches events at the edge on which they are present. Event bit layout: bits 4:0 are bit error, desync, parity, timeout and length error. Bit 5 is overrun, bits 9:6 are group-complete for groups 0..3, and bits 13:10 are group-suspend for groups 0..3. Writing 1 to a flag bit clears it. A new event wins over a clear in the same cycle.
- R5: A line is high while any flag is set whose enable bit is 1 and whose select bit routes it there: select 0 means line 0, select 1 means line 1. With all enables at 0, both lines stay low.
- R6: A line's vector ignores the enable bits. If any group event is pending on that line, the vector is 1+2g for a completed group g or 2+2g for a suspended group g. The lowest pending group wins, and within one group completion wins over suspension.
- R7: If no group event is pending on a line but any error, including overrun, is pending there, the vector is 0x1F, whichever error it is. With nothing pending, the vector is 0.
- R8: `uerr_o` is high only when the multi-buffer mode bit, the parity-check bit and the parity-error flag are all 1.
- R9: The register map is as follows. Address 0 holds the enables in bits 13:0, multi-buffer mode in bit 14 and parity checking in bit 15. Address 1 holds the line selects in bits 13:0. Address 2 holds the flags. Address 3 holds the line 0 vector in bits 4:0 and the line 1 vector in bits 12:8. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_done_i | input | 4 | Per-group completion pulses |
| grp_susp_i | input | 4 | Per-group suspension pulses |
| err_i | input | 5 | Error pulses: bit, desync, parity, timeout, length |
| rxw_en_i | input | 1 | Receive RAM write strobe |
| rxw_addr_i | input | 4 | Receive RAM write slot |
| rxr_en_i | input | 1 | Receive slot read strobe |
| rxr_addr_i | input | 4 | Receive slot being read |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_line_o | output | 2 | Interrupt lines 0 and 1 |
| uerr_o | output | 1 | Uncorrectable RAM error line |
| slot_empty_o | output | 16 | Per-slot empty bits |
| slot_ovr_o | output | 16 | Per-slot overrun bits |

## Verification
The bench targets the vector priorities. It fires a suspend on a low group together with a completion on a higher group, and a completion together with a suspend in the same group. It also fires errors and group events on the same line. A wrong priority chain would report the higher group or the error code. Disabled sources are checked to still shape the vector while the line stays low, which catches a design that gates the vector with the enable. For overruns, the bench covers a second write into an unread slot, a read and a write hitting one slot in the same cycle, and an event meeting a write-one-clear in the same cycle. A wrong ordering in any of these would leave a phantom overrun or drop a flag. The uncorrectable output is tried with each gating bit missing.

// File: rtl/sirq_pkg.sv
// Shared constants and types for the serial interrupt router.
// Assumes five engine error inputs plus one overrun source.
package sirq_pkg;
    localparam int NUM_ERR  = 6;       // five engine errors plus overrun
    localparam int ERR_PAR  = 2;       // parity error position
    localparam int ERR_OVR  = 5;       // overrun position
    localparam int VEC_W    = 5;
    localparam logic [VEC_W-1:0] VEC_ERR = 5'h1F;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_SELECT = 2'd1,
        RA_FLAGS  = 2'd2,
        RA_VECTOR = 2'd3
    } reg_addr_t;
endpackage

// File: rtl/sirq_slot_status.sv
// Per-slot empty/overrun tracking for the receive buffer.
// Observes the RAM write port and the slot-read strobe; a read and a write
// of the same slot in one cycle are ordered read-then-write.
module sirq_slot_status #(
    parameter int NUM_SLOTS = 16,
    localparam int AW = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic                 rd_en,
    input  logic [AW-1:0]        rd_addr,
    output logic [NUM_SLOTS-1:0] empty_o,
    output logic [NUM_SLOTS-1:0] ovr_o,
    output logic                 ovr_event_o
);
    logic [NUM_SLOTS-1:0] slot_evt;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit_w, hit_r;
        assign hit_w = wr_en && (wr_addr == AW'(i));
        assign hit_r = rd_en && (rd_addr == AW'(i));
        // An overrun needs a write into a slot not freed in this cycle.
        assign slot_evt[i] = hit_w && !hit_r && !empty_o[i];

        // Update this slot's empty and overrun bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                empty_o[i] <= 1'b1;
                ovr_o[i]   <= 1'b0;
            end else if (hit_w) begin
                empty_o[i] <= 1'b0;
                ovr_o[i]   <= hit_r ? 1'b0 : (ovr_o[i] | !empty_o[i]);
            end else if (hit_r) begin
                empty_o[i] <= 1'b1;
                ovr_o[i]   <= 1'b0;
            end
        end
    end

    assign ovr_event_o = |slot_evt;
endmodule

// File: rtl/sirq_flag_bank.sv
// Write-one-to-clear event flags; a set in the same cycle beats a clear.
module sirq_flag_bank #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    // Latch new events and drop the bits software acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/sirq_level_arb.sv
// Per-line line drive and vector selection.
// The vector ignores enables; the line honours them. Group events outrank
// errors, lower groups outrank higher, completion outranks suspension.
module sirq_level_arb
    import sirq_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    localparam int EVW      = NUM_ERR + 2 * NUM_GROUPS,
    localparam int DONE_LSB = NUM_ERR,
    localparam int SUSP_LSB = NUM_ERR + NUM_GROUPS
) (
    input  logic [EVW-1:0]              flags_i,
    input  logic [EVW-1:0]              en_i,
    input  logic [EVW-1:0]              sel_i,
    output logic [1:0]                  line_o,
    output logic [1:0][VEC_W-1:0]       vec_o
);
    for (genvar L = 0; L < 2; L++) begin : g_line
        logic [EVW-1:0]   mapped;
        logic [VEC_W-1:0] vec;

        assign mapped    = flags_i & ((L == 1) ? sel_i : ~sel_i);
        assign line_o[L] = |(mapped & en_i);

        // Walk from lowest priority to highest so the last hit wins.
        always_comb begin
            vec = '0;
            if (|mapped[NUM_ERR-1:0]) vec = VEC_ERR;
            for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
                if (mapped[SUSP_LSB + g]) vec = VEC_W'(2 * g + 2);
                if (mapped[DONE_LSB + g]) vec = VEC_W'(2 * g + 1);
            end
        end

        assign vec_o[L] = vec;
    end
endmodule

// File: rtl/sirq_router.sv
// Top of the two-line serial interrupt router.
// Holds the enable/select/mode registers, gathers event pulses into the
// flag bank and presents per-line vectors. Assumes single-cycle pulses.
module sirq_router
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS  = 16,
    parameter int NUM_GROUPS = 4,
    localparam int AW  = $clog2(NUM_SLOTS),
    localparam int EVW = NUM_ERR + 2 * NUM_GROUPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] grp_done_i,
    input  logic [NUM_GROUPS-1:0] grp_susp_i,
    input  logic [NUM_ERR-2:0]    err_i,
    input  logic                  rxw_en_i,
    input  logic [AW-1:0]         rxw_addr_i,
    input  logic                  rxr_en_i,
    input  logic [AW-1:0]         rxr_addr_i,
    input  logic                  reg_we_i,
    input  logic [1:0]            reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic [1:0]            irq_line_o,
    output logic                  uerr_o,
    output logic [NUM_SLOTS-1:0]  slot_empty_o,
    output logic [NUM_SLOTS-1:0]  slot_ovr_o
);
    logic [EVW-1:0]         en_q, sel_q, flags_q, ev_set, ev_clr;
    logic                   mb_q, par_q, ovr_evt;
    logic [1:0][VEC_W-1:0]  vec;
    reg_addr_t              ra;

    assign ra = reg_addr_t'(reg_addr_i);

    sirq_slot_status #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (rxw_en_i),
        .wr_addr    (rxw_addr_i),
        .rd_en      (rxr_en_i),
        .rd_addr    (rxr_addr_i),
        .empty_o    (slot_empty_o),
        .ovr_o      (slot_ovr_o),
        .ovr_event_o(ovr_evt)
    );

    assign ev_set = {grp_susp_i, grp_done_i, ovr_evt, err_i};
    assign ev_clr = (reg_we_i && ra == RA_FLAGS) ? reg_wdata_i[EVW-1:0] : '0;

    sirq_flag_bank #(.WIDTH(EVW)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .flags_o(flags_q)
    );

    // Software-written enable, select and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
            mb_q  <= 1'b0;
            par_q <= 1'b0;
        end else if (reg_we_i) begin
            if (ra == RA_ENABLE) begin
                en_q  <= reg_wdata_i[EVW-1:0];
                mb_q  <= reg_wdata_i[EVW];
                par_q <= reg_wdata_i[EVW+1];
            end
            if (ra == RA_SELECT) sel_q <= reg_wdata_i[EVW-1:0];
        end
    end

    sirq_level_arb #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
        .flags_i(flags_q),
        .en_i   (en_q),
        .sel_i  (sel_q),
        .line_o (irq_line_o),
        .vec_o  (vec)
    );

    assign uerr_o = mb_q && par_q && flags_q[ERR_PAR];

    // Combinational register read mux.
    always_comb begin
        reg_rdata_o = '0;
        unique case (ra)
            RA_ENABLE: reg_rdata_o[EVW+1:0] = {par_q, mb_q, en_q};
            RA_SELECT: reg_rdata_o[EVW-1:0] = sel_q;
            RA_FLAGS:  reg_rdata_o[EVW-1:0] = flags_q;
            RA_VECTOR: begin
                reg_rdata_o[VEC_W-1:0]   = vec[0];
                reg_rdata_o[8+:VEC_W]    = vec[1];
            end
        endcase
    end
endmodule

// File: rtl/sirq_router_chk.sv
// Assertion checker for sirq_router, attached by bind.
module sirq_router_chk
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS  = 16,
    parameter int NUM_GROUPS = 4,
    localparam int AW  = $clog2(NUM_SLOTS),
    localparam int EVW = NUM_ERR + 2 * NUM_GROUPS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rxw_en,
    input logic [AW-1:0]        rxw_addr,
    input logic                 rxr_en,
    input logic [AW-1:0]        rxr_addr,
    input logic [NUM_ERR-2:0]   err,
    input logic [EVW-1:0]       flags,
    input logic [EVW-1:0]       en,
    input logic [EVW-1:0]       sel,
    input logic [1:0]           line,
    input logic [31:0]          rdata,
    input logic [1:0]           raddr,
    input logic                 mb,
    input logic                 par,
    input logic                 uerr,
    input logic [NUM_SLOTS-1:0] empty,
    input logic [NUM_SLOTS-1:0] ovr
);
    localparam int DONE_LSB = NUM_ERR;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && &empty && ovr == '0 && line == 2'b00));

    a_r2_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rxw_en && !empty[rxw_addr] && !(rxr_en && rxr_addr == rxw_addr))
        |=> (ovr[$past(rxw_addr)] && flags[ERR_OVR]));

    a_r3_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (rxr_en && !(rxw_en && rxw_addr == rxr_addr))
        |=> (empty[$past(rxr_addr)] && !ovr[$past(rxr_addr)]));

    a_r4_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|err) |=> ((flags[NUM_ERR-2:0] & $past(err)) == $past(err)));

    a_r5_no_line_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (line == 2'b00));

    a_r6_group_beats_error: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr == 2'd3 && |(flags[EVW-1:DONE_LSB] & ~sel[EVW-1:DONE_LSB]))
        |-> (rdata[VEC_W-1:0] != VEC_ERR && rdata[VEC_W-1:0] != '0));

    a_r8_uerr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        uerr |-> (mb && par));
endmodule

bind sirq_router sirq_router_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_GROUPS(NUM_GROUPS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxw_en  (rxw_en_i),
    .rxw_addr(rxw_addr_i),
    .rxr_en  (rxr_en_i),
    .rxr_addr(rxr_addr_i),
    .err     (err_i),
    .flags   (flags_q),
    .en      (en_q),
    .sel     (sel_q),
    .line    (irq_line_o),
    .rdata   (reg_rdata_o),
    .raddr   (reg_addr_i),
    .mb      (mb_q),
    .par     (par_q),
    .uerr    (uerr_o),
    .empty   (slot_empty_o),
    .ovr     (slot_ovr_o)
);

// File: tb/test_sirq_router.sv
module test_sirq_router;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [13:0] en;
        logic [13:0] sel;
        logic [3:0]  done;
        logic [3:0]  susp;
        logic [4:0]  err;
        logic [1:0]  line;
        logic [4:0]  v0;
        logic [4:0]  v1;
    } tv_t;

    // Routing and priority table (R5, R6, R7).
    localparam tv_t TBL [9] = '{
        '{14'h3FFF, 14'h0000, 4'b0010, 4'b0000, 5'b00000, 2'b01, 5'd3,  5'd0 },
        '{14'h3FFF, 14'h3FFF, 4'b0000, 4'b0100, 5'b00000, 2'b10, 5'd0,  5'd6 },
        '{14'h3FFF, 14'h0000, 4'b1000, 4'b0001, 5'b00001, 2'b01, 5'd2,  5'd0 },
        '{14'h3FFF, 14'h0000, 4'b0000, 4'b0000, 5'b10100, 2'b01, 5'h1F, 5'd0 },
        '{14'h0000, 14'h0000, 4'b0000, 4'b0000, 5'b00010, 2'b00, 5'h1F, 5'd0 },
        '{14'h3FFF, 14'h3FC0, 4'b0001, 4'b0000, 5'b01000, 2'b11, 5'h1F, 5'd1 },
        '{14'h3FFF, 14'h3FFF, 4'b0100, 4'b0100, 5'b00000, 2'b10, 5'd0,  5'd5 },
        '{14'h003F, 14'h0000, 4'b0001, 4'b0000, 5'b00000, 2'b00, 5'd1,  5'd0 },
        '{14'h3FFF, 14'h0010, 4'b0000, 4'b0000, 5'b10001, 2'b11, 5'h1F, 5'h1F}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  grp_done, grp_susp;
    logic [4:0]  err;
    logic        rxw_en, rxr_en;
    logic [3:0]  rxw_addr, rxr_addr;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [1:0]  irq_line;
    logic        uerr;
    logic [15:0] slot_empty, slot_ovr;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sirq_router i_sirq_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_done_i  (grp_done),
        .grp_susp_i  (grp_susp),
        .err_i       (err),
        .rxw_en_i    (rxw_en),
        .rxw_addr_i  (rxw_addr),
        .rxr_en_i    (rxr_en),
        .rxr_addr_i  (rxr_addr),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_line_o  (irq_line),
        .uerr_o      (uerr),
        .slot_empty_o(slot_empty),
        .slot_ovr_o  (slot_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] d, input logic [3:0] s, input logic [4:0] e);
        @(negedge clk);
        grp_done = d; grp_susp = s; err = e;
        @(negedge clk);
        grp_done = '0; grp_susp = '0; err = '0;
    endtask

    task automatic slot_op(input bit w, input bit r, input logic [3:0] a);
        @(negedge clk);
        rxw_en = w; rxr_en = r; rxw_addr = a; rxr_addr = a;
        @(negedge clk);
        rxw_en = 1'b0; rxr_en = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; grp_done = '0; grp_susp = '0; err = '0;
        rxw_en = 1'b0; rxr_en = 1'b0; rxw_addr = '0; rxr_addr = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 lines", 32'(irq_line), 32'h0);
        chk("R1 empty", 32'(slot_empty), 32'hFFFF);
        chk("R1 ovr", 32'(slot_ovr), 32'h0);
        reg_rd(2'd2, rd); chk("R1 flags", rd, 32'h0);
        reg_rd(2'd3, rd); chk("R1 vectors", rd, 32'h0);
        reg_rd(2'd0, rd); chk("R1 enables", rd, 32'h0);

        // R5 R6 R7: table walk
        foreach (TBL[i]) begin
            reg_wr(2'd2, 32'hFFFF_FFFF);
            reg_wr(2'd0, 32'(TBL[i].en));
            reg_wr(2'd1, 32'(TBL[i].sel));
            pulse(TBL[i].done, TBL[i].susp, TBL[i].err);
            chk($sformatf("R5 line row %0d", i), 32'(irq_line), 32'(TBL[i].line));
            reg_rd(2'd3, rd);
            chk($sformatf("R6/R7 vec0 row %0d", i), 32'(rd[4:0]), 32'(TBL[i].v0));
            chk($sformatf("R6/R7 vec1 row %0d", i), 32'(rd[12:8]), 32'(TBL[i].v1));
        end

        // R2: overrun detection, overrun routed to line 1
        reg_wr(2'd2, 32'hFFFF_FFFF);
        reg_wr(2'd0, 32'h3FFF);
        reg_wr(2'd1, 32'h0020);
        slot_op(1'b1, 1'b0, 4'd3);
        chk("R2 first write empty", 32'(slot_empty[3]), 32'h0);
        chk("R2 first write no ovr", 32'(slot_ovr[3]), 32'h0);
        reg_rd(2'd2, rd); chk("R2 no global ovr", rd, 32'h0);
        slot_op(1'b1, 1'b0, 4'd3);
        chk("R2 slot ovr", 32'(slot_ovr[3]), 32'h1);
        reg_rd(2'd2, rd); chk("R2 global ovr", rd, 32'h20);
        chk("R5 ovr line", 32'(irq_line), 32'h2);
        reg_rd(2'd3, rd); chk("R7 ovr vector", rd, 32'h1F00);

        // R3: read frees slot; global flag remains
        slot_op(1'b0, 1'b1, 4'd3);
        chk("R3 empty after read", 32'(slot_empty[3]), 32'h1);
        chk("R3 ovr after read", 32'(slot_ovr[3]), 32'h0);
        chk("R4 global kept", 32'(irq_line), 32'h2);

        // R4: write-one-clear
        reg_wr(2'd2, 32'h20);
        reg_rd(2'd2, rd); chk("R4 cleared", rd, 32'h0);
        chk("R4 line drops", 32'(irq_line), 32'h0);

        // R3: same-cycle read and write of a filled slot
        slot_op(1'b1, 1'b0, 4'd5);
        slot_op(1'b1, 1'b1, 4'd5);
        chk("R3 tie empty", 32'(slot_empty[5]), 32'h0);
        chk("R3 tie ovr", 32'(slot_ovr[5]), 32'h0);
        reg_rd(2'd2, rd); chk("R3 tie no flag", rd, 32'h0);

        // R4: set beats clear in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h3; err = 5'b00001;
        @(negedge clk);
        reg_we = 1'b0; err = '0;
        reg_rd(2'd2, rd); chk("R4 set wins", rd, 32'h1);
        reg_wr(2'd2, 32'h1);

        // R8: uncorrectable-error gating
        pulse(4'b0, 4'b0, 5'b00100);
        chk("R8 no mode", 32'(uerr), 32'h0);
        reg_wr(2'd0, 32'h7FFF);
        chk("R8 mb only", 32'(uerr), 32'h0);
        reg_wr(2'd0, 32'hBFFF);
        chk("R8 par only", 32'(uerr), 32'h0);
        reg_wr(2'd0, 32'hFFFF);
        chk("R8 both", 32'(uerr), 32'h1);
        reg_rd(2'd0, rd); chk("R9 enable readback", rd, 32'hFFFF);
        reg_rd(2'd1, rd); chk("R9 select readback", rd, 32'h0020);
        reg_wr(2'd2, 32'h4);
        chk("R8 flag cleared", 32'(uerr), 32'h0);

        summary();
    end
endmodule